// File: doc/BRIEF.md
# Six-Stage Token Pipeline with Two-Cycle Execute

This block models an in-order, six-stage instruction pipeline for throughput studies. It has no real instructions. Each instruction is a token that carries only an ID. Tokens enter stage S1 from a feed port, one per cycle, whenever S1 can take one. They move through S2 and S3 and then reach the execute stage S4, which holds each token for two clock cycles. After S4 they pass through S5 and S6 and leave the pipeline.

With one execute unit, a token waiting in S3 stalls while S4 is busy. The stall spreads back to S1, and empty slots (bubbles) move on to S5. When `dual_mode` is set, two execute units take tokens in strict turn. Tokens still leave in program order, and the stall caused by the two-cycle stage disappears.

The block reports which stages hold a token, a retire strobe with the ID of the retiring token, and a count of the cycles in which the pipeline held any token. This lets a run of n back-to-back tokens be compared with the pipeline timing formulas.

Top module: `tok_pipe_timing`

## Requirements
- R1: During and after a synchronous active-high reset, `occupancy` is 0, `retire_valid` is 0, `cycle_count` is 0 and `feed_ready` is 1.
- R2: A token is accepted at a rising edge where both `feed_valid` and `feed_ready` are high. It occupies S1 in the following cycle, and S1, S2, S3, S5 and S6 each hold a token for one cycle when there is no stall.
- R3: Each execute unit holds a token for exactly two consecutive cycles before passing it to S5.
- R4: In single-unit mode, a token in S3 stays there while the execute unit is busy and not finishing. Earlier stages hold their tokens and `feed_ready` drops. Back-to-back tokens therefore retire 2 cycles apart.
- R5: In dual-unit mode, tokens go to the two execute units in strict turn. Back-to-back tokens retire on consecutive cycles.
- R6: Tokens retire in the order they were accepted, each with the ID it was fed with, including when the feed has gaps.
- R7: `cycle_count` goes up by one for each cycle in which any stage holds a token and stays the same otherwise. For n back-to-back tokens after reset it ends at 6+2n-1 in single-unit mode and at 6+n in dual-unit mode.
- R8: Bit i of `occupancy` (i = 0..5) shows that stage S(i+1) holds a token. Bit 3 is set when either execute unit holds a token. `retire_valid` is high for exactly the cycle in which a token is in S6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 = two execute units used in turn; change it only when the pipeline is empty |
| feed_valid | input | 1 | A token is offered |
| feed_id | input | 8 | ID of the offered token |
| feed_ready | output | 1 | S1 can take a token at the next edge |
| occupancy | output | 6 | Per-stage valid bits, bit 0 = S1 |
| retire_valid | output | 1 | A token is retiring from S6 this cycle |
| retire_id | output | 8 | ID of the retiring token |
| cycle_count | output | 16 | Cycles with any stage occupied since reset |

## Verification
The bench drives inputs and samples outputs on falling edges, so every cycle has a fixed index.

- **Entry:** A token offered while `feed_ready` is high must appear in `occupancy` bit 0 at the next sample.
- **Single-token path:** For one token, the occupancy sequence must be S1, S2, S3, S4, S4, S5, S6 on seven consecutive samples. The retire strobe must come on the seventh.
- **Streams:** For streams, retire spacing must be 2 cycles (single unit) or 1 cycle (dual units). After the last retire, `cycle_count` is read once the pipeline is empty and compared with the formula and with the bench's own count of occupied samples.

// File: rtl/tok_pipe_pkg.sv
package tok_pipe_pkg;
  localparam int TOK_ID_W = 8;

  typedef struct packed {
    logic                valid;
    logic [TOK_ID_W-1:0] id;
  } token_t;
endpackage

// File: rtl/pt_exec_unit.sv
module pt_exec_unit
  import tok_pipe_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  token_t tin,
  output token_t hold,
  output logic   done,
  output logic   ready
);
  localparam int PH_W = (LAT > 1) ? $clog2(LAT) : 1;

  logic [PH_W-1:0] phase;

  assign done  = hold.valid && (phase == PH_W'(LAT - 1));
  assign ready = !hold.valid || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= '0;
      phase <= '0;
    end else if (load) begin
      hold  <= tin;
      phase <= '0;
    end else if (done) begin
      hold.valid <= 1'b0;
    end else if (hold.valid) begin
      phase <= phase + 1'b1;
    end
  end

  // R3: a token not yet finished stays in the unit unchanged
  a_r3_unit_holds: assert property (@(posedge clk) disable iff (rst)
    hold.valid && !done |=> hold.valid && $stable(hold.id));
endmodule

// File: rtl/pt_exec_cluster.sv
module pt_exec_cluster
  import tok_pipe_pkg::*;
#(
  parameter int LAT   = 2,
  parameter int UNITS = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   dual,
  input  token_t tin,
  output logic   ready,
  output token_t tout,
  output logic   busy
);
  localparam int PW = (UNITS > 1) ? $clog2(UNITS) : 1;

  logic [UNITS-1:0] u_done, u_ready, u_load, u_busy;
  token_t           u_hold [UNITS];
  logic [PW-1:0]    ptr, target;

  assign target = dual ? ptr : '0;
  assign ready  = u_ready[target];

  genvar u;
  generate
    for (u = 0; u < UNITS; u++) begin : g_unit
      assign u_load[u] = tin.valid && ready && (target == PW'(u));
      assign u_busy[u] = u_hold[u].valid;
      pt_exec_unit #(.LAT(LAT)) unit_i (
        .clk  (clk),
        .rst  (rst),
        .load (u_load[u]),
        .tin  (tin),
        .hold (u_hold[u]),
        .done (u_done[u]),
        .ready(u_ready[u])
      );
    end
  endgenerate

  assign busy = |u_busy;

  always_comb begin
    tout = '0;
    for (int k = 0; k < UNITS; k++) begin
      if (u_done[k]) tout = u_hold[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !dual) begin
      ptr <= '0;
    end else if (tin.valid && ready) begin
      ptr <= (ptr == PW'(UNITS - 1)) ? '0 : ptr + 1'b1;
    end
  end

  // R6: units never finish together, so retire order is the dispatch order
  a_r6_one_finish: assert property (@(posedge clk) disable iff (rst)
    $countones(u_done) <= 1);

  // R5: single-unit mode never dispatches to a second unit
  a_r5_single_uses_first: assert property (@(posedge clk) disable iff (rst)
    !dual && tin.valid && ready |=> u_busy[0]);
endmodule

// File: rtl/pt_cycle_meter.sv
module pt_cycle_meter #(
  parameter int STAGES = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] occ,
  output logic [CNT_W-1:0]  count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (|occ) count <= count + 1'b1;
  end
endmodule

// File: rtl/tok_pipe_timing.sv
module tok_pipe_timing
  import tok_pipe_pkg::*;
#(
  parameter int FRONT = 3,
  parameter int BACK  = 2,
  parameter int LAT   = 2,
  parameter int UNITS = 2,
  parameter int CNT_W = 16,
  localparam int STAGES = FRONT + 1 + BACK
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dual_mode,
  input  logic                feed_valid,
  input  logic [TOK_ID_W-1:0] feed_id,
  output logic                feed_ready,
  output logic [STAGES-1:0]   occupancy,
  output logic                retire_valid,
  output logic [TOK_ID_W-1:0] retire_id,
  output logic [CNT_W-1:0]    cycle_count
);
  token_t           st   [FRONT];
  token_t           bk   [BACK];
  logic [FRONT-1:0] mv;
  token_t           feed_tok, ex_out;
  logic             ex_ready, ex_busy;

  assign feed_tok = '{valid: feed_valid, id: feed_id};

  genvar i;
  generate
    for (i = 0; i < FRONT; i++) begin : g_front
      token_t up;
      logic   leave;
      if (i == 0) begin : g_in
        assign up = feed_tok;
      end else begin : g_mid
        assign up = st[i-1];
      end
      if (i == FRONT - 1) begin : g_last
        assign leave = ex_ready;
      end else begin : g_pass
        assign leave = mv[i+1];
      end
      assign mv[i] = !st[i].valid || leave;
      always_ff @(posedge clk) begin
        if (rst)        st[i] <= '0;
        else if (mv[i]) st[i] <= up;
      end
      assign occupancy[i] = st[i].valid;
    end

    for (i = 0; i < BACK; i++) begin : g_back
      always_ff @(posedge clk) begin
        if (rst)         bk[i] <= '0;
        else if (i == 0) bk[i] <= ex_out;
        else             bk[i] <= bk[i-1];
      end
      assign occupancy[FRONT+1+i] = bk[i].valid;
    end
  endgenerate

  pt_exec_cluster #(.LAT(LAT), .UNITS(UNITS)) exec_i (
    .clk  (clk),
    .rst  (rst),
    .dual (dual_mode),
    .tin  (st[FRONT-1]),
    .ready(ex_ready),
    .tout (ex_out),
    .busy (ex_busy)
  );

  assign occupancy[FRONT] = ex_busy;
  assign feed_ready       = mv[0];
  assign retire_valid     = bk[BACK-1].valid;
  assign retire_id        = bk[BACK-1].id;

  pt_cycle_meter #(.STAGES(STAGES), .CNT_W(CNT_W)) meter_i (
    .clk  (clk),
    .rst  (rst),
    .occ  (occupancy),
    .count(cycle_count)
  );

  // R2: an accepted token appears in S1 with its ID
  a_r2_entry: assert property (@(posedge clk) disable iff (rst)
    feed_valid && feed_ready |=> occupancy[0] && (st[0].id == $past(feed_id)));

  // R4: a token waiting on a busy execute stage stays put
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (rst)
    st[FRONT-1].valid && !ex_ready |=> st[FRONT-1].valid && $stable(st[FRONT-1].id));

  // R7: the counter advances while occupied and holds while empty
  a_r7_count_busy: assert property (@(posedge clk) disable iff (rst)
    (|occupancy) |=> cycle_count == $past(cycle_count) + 1'b1);
  a_r7_count_idle: assert property (@(posedge clk) disable iff (rst)
    (occupancy == '0) |=> $stable(cycle_count));
endmodule

// File: tb/tok_pipe_timing_test.sv
module tok_pipe_timing_test;
  logic        clk = 1'b0;
  logic        rst, dual_mode, feed_valid;
  logic [7:0]  feed_id;
  logic        feed_ready, retire_valid;
  logic [5:0]  occupancy;
  logic [7:0]  retire_id;
  logic [15:0] cycle_count;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tok_pipe_timing uut (
    .clk(clk), .rst(rst), .dual_mode(dual_mode), .feed_valid(feed_valid),
    .feed_id(feed_id), .feed_ready(feed_ready), .occupancy(occupancy),
    .retire_valid(retire_valid), .retire_id(retire_id), .cycle_count(cycle_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input int n, input bit dual);
    return dual ? 6 + n : 6 + 2 * n - 1;
  endfunction

  function automatic int stage_at(input int idx);
    if (idx < 3) return idx;
    if (idx < 5) return 3;
    return idx - 1;
  endfunction

  task automatic run_stream(input int n, input bit dual, input bit gaps);
    logic [7:0] ids [32];
    int sent = 0, got = 0, occ_cycles = 0, last_ret = -1, cyc = 0;
    bit saw_stall = 0;
    for (int k = 0; k < 32; k++) ids[k] = 8'($urandom);
    rst = 1'b1; feed_valid = 1'b0; feed_id = '0; dual_mode = dual;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(occupancy == 0 && !retire_valid && cycle_count == 0 && feed_ready,
          "R1 reset state", int'(occupancy), 0);
    rst = 1'b0;
    while ((got < n || occupancy != 0) && cyc < 2000) begin
      if (occupancy != 0) begin
        if (n == 1)  // R8 R3 R2: single token walks S1..S6 with two cycles in S4
          check(occupancy == 6'(1 << stage_at(occ_cycles)), "R8 occupancy path",
                int'(occupancy), 1 << stage_at(occ_cycles));
        occ_cycles++;
      end
      if (retire_valid) begin
        check(got < n && retire_id == ids[got], "R6 retire order",
              int'(retire_id), int'(ids[got]));
        if (!gaps && got > 0)
          check(cyc - last_ret == (dual ? 1 : 2), dual ? "R5 retire spacing" : "R4 retire spacing",
                cyc - last_ret, dual ? 1 : 2);
        if (n == 1) check(occ_cycles == 7, "R2 retire latency", occ_cycles, 7);
        last_ret = cyc;
        got++;
      end
      if (sent > 0 && sent < n && !feed_ready) saw_stall = 1;
      if (sent < n && !(gaps && ($urandom % 3 == 0))) begin
        feed_valid = 1'b1;
        feed_id    = ids[sent];
        if (feed_ready) sent++;
      end else begin
        feed_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    feed_valid = 1'b0;
    check(got == n, "R6 all retired", got, n);
    check(int'(cycle_count) == occ_cycles, "R7 counts occupied cycles", int'(cycle_count), occ_cycles);
    if (!gaps)
      check(int'(cycle_count) == exp_cycles(n, dual), "R7 cycle formula",
            int'(cycle_count), exp_cycles(n, dual));
    if (!dual && !gaps && n >= 4) check(saw_stall, "R4 feed stalls", saw_stall, 1);
    if (dual && !gaps && n >= 4) check(!saw_stall, "R5 no stall", saw_stall, 0);
    repeat (3) @(negedge clk);
    check(int'(cycle_count) == occ_cycles, "R7 count holds when empty", int'(cycle_count), occ_cycles);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    run_stream(1, 1'b0, 1'b0);
    run_stream(1, 1'b1, 1'b0);
    run_stream(2, 1'b0, 1'b0);
    run_stream(8, 1'b0, 1'b0);
    run_stream(8, 1'b1, 1'b0);
    run_stream(20, 1'b0, 1'b0);
    run_stream(20, 1'b1, 1'b0);
    for (int r = 0; r < 6; r++) run_stream(5 + r * 4, r[0], 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule